// File: doc/BRIEF.md
# Seven-Level Level-Shifted Carrier PWM Modulator

This block modulates one phase leg of a seven-level inverter. The leg is built from two cascaded H-bridges, and their DC supplies are in a 2:1 ratio. A free-running phase counter produces one triangle, and six triangular carriers are formed from it. Each carrier sits in its own adjacent, non-overlapping vertical band. Together the six bands cover the signed reference range symmetrically about zero. The block samples the reference, compares it against all six carriers and counts how many carriers the reference exceeds. That count minus three is the target level, from -3 to +3 in half-supply steps.

The target level is split into a full-step digit for the high-voltage bridge and a half-step digit for the low-voltage bridge. Each digit becomes four switch commands. A two-bit mode input selects how the carriers are phased against each other: all in phase, upper and lower groups opposed, or alternating band by band. A new mode is taken only when a carrier period ends. All state advances on a shared clock enable, which sets the carrier rate.

Top module: `lsc_pwm_leg`

## Requirements
- R1: With B = 2^CW, the phase counter p runs 0..2B-1 and advances by one on each enabled clock. The base triangle is t = p for p < B and 2B-1-p otherwise. Carrier k (k = 0..5) is (k-3)·B + t when it is in phase, and (k-3)·B + (B-1-t) when it is in antiphase.
- R2: Mode 0 (and mode 3, which is treated as mode 0) puts all six carriers in phase.
- R3: Mode 1 puts carriers 3..5 (above zero) in phase and carriers 0..2 (below zero) in antiphase.
- R4: Mode 2 puts even-numbered carriers in phase and odd-numbered carriers in antiphase, so that vertical neighbours are always opposed.
- R5: A comparator is active when the sampled reference is strictly greater than its carrier. The level is the number of active comparators minus 3, and it is output as a 3-bit two's complement value.
- R6: The level L is split into digits d1 (full step) and d2 (half step), each in {-1, 0, +1}, with 2·d1 + d2 = L. d1 is nonzero only when |L| >= 2, and d2 is nonzero only when L is odd.
- R7: Each bridge uses a 4-bit gate field: bit0 upper-left, bit1 lower-left, bit2 upper-right, bit3 lower-right. A digit of +1 gives 4'b1001, -1 gives 4'b0110 and 0 gives 4'b1010. gate[3:0] belongs to the full-step bridge and gate[7:4] to the half-step bridge. The two switches of one half-bridge are never on together.
- R8: On an enabled clock the reference is sampled. In the same clock, level and gate are registered from the previously sampled reference, the pre-edge phase and the active mode, so they lag the sample by one enabled clock. When the enable is low, no state and no output changes.
- R9: A new mode value is adopted only on the enabled clock that wraps the phase from 2B-1 to 0.
- R10: Reset sets the phase to 0, the sample to 0, the mode to 0, the level to 0 and gate to 8'hAA.
- R11: A sampled reference of at least 3B gives level +3 at every phase. A sampled reference of at most -3B gives level -3 at every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable that advances carriers, sample and outputs |
| mode_in | input | 2 | Carrier disposition: 0 in phase, 1 groups opposed, 2 alternating |
| ref_in | input | CW+3 | Signed reference sample |
| gate | output | 8 | Switch commands for both bridges |
| level | output | 3 | Signed target level, -3..+3 |

## Verification
A wrong phase count or a wrong carrier orientation shifts the comparison instants. Within one carrier period this shows up as a level that disagrees with the reference model at the ticks near a band crossing. A stale or early mode register would make the level diverge from the model inside the period where the mode changed, and that period is checked tick by tick. A corrupted bridge split would show on gate as a code that differs from the expected field on the very next enabled clock, even while level stays correct.

// File: rtl/lsc_pwm_leg.sv
module lsc_pwm_leg #(
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic [1:0]           mode_in,
  input  logic signed [CW+2:0] ref_in,
  output logic [7:0]           gate,
  output logic signed [2:0]    level
);
  localparam int RW = CW + 3;
  localparam int B = 1 << CW;
  localparam logic [CW:0] PMAX = '1;
  localparam logic [3:0] SW_POS = 4'b1001;
  localparam logic [3:0] SW_NEG = 4'b0110;
  localparam logic [3:0] SW_ZER = 4'b1010;

  logic [CW:0]          phase;
  logic signed [RW-1:0] ref_q;
  logic [1:0]           mode_q;
  logic [CW-1:0]        tri_up, tri_dn;
  logic [5:0]           above;
  logic [2:0]           n_act;
  logic signed [2:0]    lvl_d;
  logic [7:0]           gate_d;

  assign tri_up = phase[CW] ? ~phase[CW-1:0] : phase[CW-1:0];
  assign tri_dn = ~tri_up;

  for (genvar k = 0; k < 6; k++) begin : g_car
    localparam logic signed [RW-1:0] BASE = RW'((k - 3) * B);
    logic inv;
    logic signed [RW-1:0] car;
    assign inv = (mode_q == 2'd1 && k < 3) || (mode_q == 2'd2 && (k % 2) == 1);
    assign car = BASE + $signed({3'b000, inv ? tri_dn : tri_up});
    assign above[k] = ref_q > car;
  end

  assign n_act = 3'($countones(above));
  assign lvl_d = $signed(n_act - 3'd3);

  always_comb begin
    case (lvl_d)
      3'sd3:   gate_d = {SW_POS, SW_POS};
      3'sd2:   gate_d = {SW_ZER, SW_POS};
      3'sd1:   gate_d = {SW_POS, SW_ZER};
      -3'sd1:  gate_d = {SW_NEG, SW_ZER};
      -3'sd2:  gate_d = {SW_ZER, SW_NEG};
      -3'sd3:  gate_d = {SW_NEG, SW_NEG};
      default: gate_d = {SW_ZER, SW_ZER};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      ref_q  <= '0;
      mode_q <= 2'd0;
      level  <= '0;
      gate   <= {SW_ZER, SW_ZER};
    end else if (ce) begin
      phase <= phase + 1'b1;
      ref_q <= ref_in;
      if (phase == PMAX) mode_q <= mode_in;
      level <= lvl_d;
      gate  <= gate_d;
    end
  end

  function automatic int dig(input logic [3:0] g);
    return (g == SW_POS) ? 1 : (g == SW_NEG) ? -1 : 0;
  endfunction

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> phase == $past(phase) + 1'b1);

  a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    level != 3'sb100);

  a_r6_digits_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (2 * dig(gate[3:0]) + dig(gate[7:4])) == int'(level));

  a_r7_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]) &&
    !(gate[4] && gate[5]) && !(gate[6] && gate[7]));

  a_r8_hold_without_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(gate) && $stable(level) && $stable(phase));

  a_r9_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(phase) == PMAX && $past(ce)));
endmodule

// File: tb/test_lsc_pwm_leg.sv
module test_lsc_pwm_leg;
  localparam int CW = 5;
  localparam int B = 1 << CW;
  localparam int RW = CW + 3;
  localparam int VN = 12;
  localparam int VREF [VN] = '{0, 10, -10, 40, -40, 70, -70, 95, -95, 17, -50, 63};
  localparam int VMODE [VN] = '{0, 1, 2, 3, 0, 1, 2, 0, 1, 2, 3, 2};

  logic clk = 0, rst_n = 0, ce = 0;
  logic [1:0] mode_in = 0;
  logic signed [RW-1:0] ref_in = 0;
  logic [7:0] gate;
  logic signed [2:0] level;

  int checks = 0, errors = 0;
  int m_phase = 0, m_ref = 0, m_mode = 0, exp_lvl = 0;
  logic [7:0] exp_gate = 8'hAA;

  lsc_pwm_leg #(.CW(CW)) i_lsc_pwm_leg (
    .clk(clk), .rst_n(rst_n), .ce(ce), .mode_in(mode_in),
    .ref_in(ref_in), .gate(gate), .level(level));

  always #4 clk = ~clk;

  function automatic int model_level(int p, int r, int m);
    int t = (p < B) ? p : 2 * B - 1 - p;
    int cnt = 0;
    for (int k = 0; k < 6; k++) begin
      bit inv = (m == 1 && k < 3) || (m == 2 && (k % 2) == 1);
      int c = (k - 3) * B + (inv ? B - 1 - t : t);
      if (r > c) cnt++;
    end
    return cnt - 3;
  endfunction

  function automatic logic [3:0] sw(int d);
    return (d > 0) ? 4'b1001 : (d < 0) ? 4'b0110 : 4'b1010;
  endfunction

  function automatic logic [7:0] model_gate(int l);
    int d1 = (l >= 2) ? 1 : (l <= -2) ? -1 : 0;
    return {sw(l - 2 * d1), sw(d1)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag, int r, int md, bit en);
    @(negedge clk);
    ref_in = RW'(r);
    mode_in = 2'(md);
    ce = en;
    @(posedge clk);
    if (en) begin
      exp_lvl = model_level(m_phase, m_ref, m_mode);
      exp_gate = model_gate(exp_lvl);
      if (m_phase == 2 * B - 1) m_mode = (md == 3) ? 0 : md;
      m_phase = (m_phase + 1) % (2 * B);
      m_ref = r;
    end
    #2;
    chk(tag, int'(level), exp_lvl);
    chk("R6 R7 gate", int'(gate), int'(exp_gate));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10 level", int'(level), 0);
    chk("R10 gate", int'(gate), 8'hAA);

    for (int v = 0; v < VN; v++) begin
      string tg = (VMODE[v] == 1) ? "R3" : (VMODE[v] == 2) ? "R4" : "R2";
      for (int n = 0; n < 4 * B; n++) tick(tg, VREF[v], VMODE[v], 1);
    end

    // R1 R5: ramped reference across all bands in phase mode
    for (int n = 0; n < 6 * B; n++) tick("R1", -3 * B - 4 + (n * 7) % (6 * B + 8), 0, 1);
    for (int n = 0; n < 2 * B; n++) tick("R5", 3 * B - 1, 0, 1);

    // R8: enable low, reference and mode moving, nothing advances
    for (int n = 0; n < 7; n++) tick("R8", 90 - 25 * n, n % 3, 0);
    for (int n = 0; n < 5; n++) tick("R8", 5, 0, 1);

    // R9: mode request mid-period is deferred to the wrap
    while (m_phase != B / 2) tick("R9", 20, 0, 1);
    for (int n = 0; n < 3 * B; n++) tick("R9", 20 - (n % 9), 2, 1);
    for (int n = 0; n < 2 * B; n++) tick("R9", -20, 1, 1);

    // R11: saturation at both extremes
    for (int n = 0; n < 2 * B + 1; n++) tick("R11", 3 * B, 2, 1);
    for (int n = 0; n < 2 * B; n++) begin
      tick("R11", -3 * B, 1, 1);
    end
    chk("R11 low", int'(level), -3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule